// File: doc/BRIEF.md
# Entropy-collection sequencer for a true random number generator

This block is the top-level sequencer of a true random number generator. It decides when the ring oscillators run and when a conditioned random word may enter the output FIFO. After enable it waits in a start-up state until every start-up test has passed or been bypassed. Only then does it admit words into the FIFO.

When the FIFO fills, the oscillators stay on for a programmable number of clock cycles and are then switched off. They stay off until software has drained the FIFO down to a refill mark given in 128-bit blocks. A force-run control keeps the oscillators on regardless of fill level. A health-test failure parks the sequencer in an error state with the oscillators stopped. Only a software reset or clearing the enable releases it.

A FIFO-full flag is raised when the fill level reaches capacity. A write to the level register clears it. The interrupt output is the flag gated by its enable bit.

Top module: `trng_seq_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (RESET), and `osc_en_o`, `fifo_wr_o`, `full_flag_o` and `irq_o` are all low. The state codes are RESET=0, STARTUP=1, FULL_WAIT=2, FULL_IDLE=3, RUNNING=4 and ERROR=5. Codes 6 and 7 never appear.
- R2: With the enable set, RESET moves to STARTUP on the next clock. In STARTUP `osc_en_o` is high and `fifo_wr_o` stays low.
- R3: STARTUP moves to RUNNING on the clock where every start-up test i has `startup_pass_i[i]` or `startup_bypass_i[i]` set. Otherwise it stays in STARTUP.
- R4: In RUNNING and FULL_WAIT, `fifo_wr_o` equals `sample_valid_i` while `fifo_level_i` is below FIFO_WORDS, and is low when the level is at or above FIFO_WORDS. In every other state it is low.
- R5: In RUNNING with the FIFO full and force-run clear, the sequencer enters FULL_WAIT with `osc_en_o` high for exactly `off_delay_i`+1 cycles. It then enters FULL_IDLE, where `osc_en_o` is low.
- R6: With force-run set, a full FIFO keeps the sequencer in RUNNING with the oscillators on. Force-run set during FULL_WAIT returns it to RUNNING.
- R7: FULL_IDLE moves to RUNNING on the clock where `fifo_level_i` is at most 4 × `restart_blocks_i` words. Above that it stays.
- R8: `health_fail_i` in STARTUP, RUNNING or FULL_WAIT moves the sequencer to ERROR (code 5). ERROR keeps `osc_en_o` low and persists until soft reset or disable.
- R9: A low enable puts the sequencer in RESET on the next clock from any state.
- R10: `soft_rst_i` puts the sequencer in RESET on the next clock and clears the full flag.
- R11: `full_flag_o` rises one clock after `fifo_level_i` first reaches FIFO_WORDS. `level_wr_i` clears it. It does not set again while the level stays full.
- R12: `irq_o` is high exactly when `full_flag_o` and `full_ien_i` are both high.
- R13: In FULL_WAIT, a level that falls below FIFO_WORDS before the timer expires returns the sequencer to RUNNING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Block enable |
| soft_rst_i | input | 1 | Software reset |
| force_run_i | input | 1 | Keep oscillators on when full |
| startup_bypass_i | input | NTESTS | Per-test start-up bypass |
| startup_pass_i | input | NTESTS | Per-test start-up pass result |
| health_fail_i | input | 1 | Continuous health-test failure |
| sample_valid_i | input | 1 | Conditioned word ready |
| fifo_level_i | input | LVL_W | FIFO fill level in 32-bit words |
| off_delay_i | input | TMR_W | Cycles to keep oscillators on after full, minus one |
| restart_blocks_i | input | BLK_W | Refill mark in 128-bit blocks |
| level_wr_i | input | 1 | Level-register write strobe |
| full_ien_i | input | 1 | Full interrupt enable |
| osc_en_o | output | 1 | Ring oscillator run enable |
| fifo_wr_o | output | 1 | FIFO write strobe |
| state_o | output | 3 | State code |
| full_flag_o | output | 1 | FIFO-full flag |
| irq_o | output | 1 | Full interrupt request |

## Verification
The sequencing is driven with start-up results arriving one test at a time, then together, and then replaced by bypass bits. This tells a gate that needs all tests apart from one that takes any single test.

The fill level is walked through four patterns:
- one word below full, which must keep writing;
- exactly full, with and without force-run;
- a drop below full inside the off-delay window;
- during the idle phase, one word above the refill mark and then exactly on it.

These patterns expose off-by-one errors in the timer and in both comparisons. Health failures, soft reset and disable are applied from several states. The full flag is raised, cleared while the level stays full, and cleared by soft reset, which separates edge-triggered from level-triggered setting.

// File: rtl/trng_seq_pkg.sv
package trng_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET    = 3'd0,
        ST_STARTUP  = 3'd1,
        ST_FULL_ON  = 3'd2,
        ST_FULL_OFF = 3'd3,
        ST_RUN      = 3'd4,
        ST_ERROR    = 3'd5
    } seq_state_e;

endpackage

// File: rtl/trng_seq_gate.sv
// Start-up gate: ready once every test has passed or is bypassed.
module trng_seq_gate #(
    parameter int NTESTS = 2
) (
    input  logic [NTESTS-1:0] pass_i,
    input  logic [NTESTS-1:0] bypass_i,
    output logic              ready_o
);
    logic [NTESTS-1:0] ok;

    for (genvar g = 0; g < NTESTS; g++) begin : g_test
        assign ok[g] = pass_i[g] | bypass_i[g];
    end

    assign ready_o = &ok;
endmodule

// File: rtl/trng_seq_offtmr.sv
// Switch-off down counter, reloaded on every entry to the timed wait.
module trng_seq_offtmr #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             done_o
);
    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.cnt = load_val_i;
        end else if (run_i && r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o = (r_q.cnt == '0);
endmodule

// File: rtl/trng_seq_fullflag.sv
// FIFO-full flag: set on the rising edge of "full", cleared by strobe.
module trng_seq_fullflag (
    input  logic clk,
    input  logic rst_n,
    input  logic full_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic full_prev;
        logic flag;
    } ff_t;

    ff_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        r_d.full_prev = full_i;
        if (full_i && !r_q.full_prev) r_d.flag = 1'b1;
        else if (clr_i)               r_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flag_o = r_q.flag;
endmodule

// File: rtl/trng_seq_ctrl.sv
module trng_seq_ctrl
    import trng_seq_pkg::*;
#(
    parameter int  FIFO_WORDS = 64,
    parameter int  TMR_W      = 16,
    parameter int  NTESTS     = 2,
    localparam int LVL_W      = $clog2(FIFO_WORDS) + 1,
    localparam int BLK_W      = LVL_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              soft_rst_i,
    input  logic              force_run_i,
    input  logic [NTESTS-1:0] startup_bypass_i,
    input  logic [NTESTS-1:0] startup_pass_i,
    input  logic              health_fail_i,
    input  logic              sample_valid_i,
    input  logic [LVL_W-1:0]  fifo_level_i,
    input  logic [TMR_W-1:0]  off_delay_i,
    input  logic [BLK_W-1:0]  restart_blocks_i,
    input  logic              level_wr_i,
    input  logic              full_ien_i,
    output logic              osc_en_o,
    output logic              fifo_wr_o,
    output logic [2:0]        state_o,
    output logic              full_flag_o,
    output logic              irq_o
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_WORDS);

    typedef struct packed {
        seq_state_e state;
    } seq_t;

    seq_t r_d, r_q;

    logic             ready;
    logic             tmr_done;
    logic             tmr_load;
    logic             fifo_full;
    logic             refill_hit;
    logic [LVL_W-1:0] restart_words;

    trng_seq_gate #(.NTESTS(NTESTS)) u_gate (
        .pass_i   (startup_pass_i),
        .bypass_i (startup_bypass_i),
        .ready_o  (ready)
    );

    assign fifo_full     = (fifo_level_i >= FULL_LVL);
    assign restart_words = {restart_blocks_i, 2'b00};
    assign refill_hit    = (fifo_level_i <= restart_words);

    always_comb begin
        r_d = r_q;
        if (!enable_i || soft_rst_i) begin
            r_d.state = ST_RESET;
        end else begin
            unique case (r_q.state)
                ST_RESET:    r_d.state = ST_STARTUP;
                ST_STARTUP: begin
                    if (health_fail_i) r_d.state = ST_ERROR;
                    else if (ready)    r_d.state = ST_RUN;
                end
                ST_RUN: begin
                    if (health_fail_i)                   r_d.state = ST_ERROR;
                    else if (fifo_full && !force_run_i) r_d.state = ST_FULL_ON;
                end
                ST_FULL_ON: begin
                    if (health_fail_i)                   r_d.state = ST_ERROR;
                    else if (!fifo_full || force_run_i) r_d.state = ST_RUN;
                    else if (tmr_done)                  r_d.state = ST_FULL_OFF;
                end
                ST_FULL_OFF: begin
                    if (refill_hit) r_d.state = ST_RUN;
                end
                ST_ERROR:    r_d.state = ST_ERROR;
                default:     r_d.state = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_RESET};
        else        r_q <= r_d;
    end

    assign tmr_load = (r_d.state == ST_FULL_ON) && (r_q.state != ST_FULL_ON);

    trng_seq_offtmr #(.TMR_W(TMR_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (off_delay_i),
        .run_i      (r_q.state == ST_FULL_ON),
        .done_o     (tmr_done)
    );

    trng_seq_fullflag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .full_i (fifo_full),
        .clr_i  (level_wr_i | soft_rst_i),
        .flag_o (full_flag_o)
    );

    assign osc_en_o  = (r_q.state == ST_STARTUP) || (r_q.state == ST_RUN) ||
                       (r_q.state == ST_FULL_ON);
    assign fifo_wr_o = sample_valid_i && !fifo_full &&
                       ((r_q.state == ST_RUN) || (r_q.state == ST_FULL_ON));
    assign state_o   = r_q.state;
    assign irq_o     = full_flag_o & full_ien_i;
endmodule

// File: rtl/trng_seq_ctrl_chk.sv
module trng_seq_ctrl_chk #(
    parameter int FIFO_WORDS = 64,
    parameter int LVL_W      = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic             soft_rst_i,
    input logic             full_ien_i,
    input logic [LVL_W-1:0] fifo_level_i,
    input logic             osc_en_o,
    input logic             fifo_wr_o,
    input logic [2:0]       state_o,
    input logic             full_flag_o,
    input logic             irq_o
);
    p_code_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd5);

    p_no_wr_startup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1) |-> !fifo_wr_o);

    p_no_wr_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level_i >= LVL_W'(FIFO_WORDS)) |-> !fifo_wr_o);

    p_idle_osc_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3) |-> !osc_en_o);

    p_err_osc_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd5) |-> !osc_en_o);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd5 && enable_i && !soft_rst_i) |=> (state_o == 3'd5));

    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (state_o == 3'd0));

    p_soft_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (state_o == 3'd0));

    p_flag_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_flag_o) |-> ($past(fifo_level_i) >= LVL_W'(FIFO_WORDS)));

    p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !full_ien_i |-> !irq_o);
endmodule

bind trng_seq_ctrl trng_seq_ctrl_chk #(
    .FIFO_WORDS (FIFO_WORDS),
    .LVL_W      (LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .soft_rst_i   (soft_rst_i),
    .full_ien_i   (full_ien_i),
    .fifo_level_i (fifo_level_i),
    .osc_en_o     (osc_en_o),
    .fifo_wr_o    (fifo_wr_o),
    .state_o      (state_o),
    .full_flag_o  (full_flag_o),
    .irq_o        (irq_o)
);

// File: tb/trng_seq_ctrl_tb.sv
module trng_seq_ctrl_tb;
    localparam int FIFO_WORDS = 64;
    localparam int LVL_W      = 7;
    localparam int NV         = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0, soft_rst_i = 1'b0, force_run_i = 1'b0;
    logic [1:0] startup_bypass_i = '0, startup_pass_i = '0;
    logic       health_fail_i = 1'b0, sample_valid_i = 1'b0;
    logic [6:0] fifo_level_i = '0;
    logic [15:0] off_delay_i = 16'd2;
    logic [4:0] restart_blocks_i = 5'd2;
    logic       level_wr_i = 1'b0, full_ien_i = 1'b0;
    logic       osc_en_o, fifo_wr_o, full_flag_o, irq_o;
    logic [2:0] state_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    trng_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .soft_rst_i(soft_rst_i),
        .force_run_i(force_run_i), .startup_bypass_i(startup_bypass_i),
        .startup_pass_i(startup_pass_i), .health_fail_i(health_fail_i),
        .sample_valid_i(sample_valid_i), .fifo_level_i(fifo_level_i),
        .off_delay_i(off_delay_i), .restart_blocks_i(restart_blocks_i),
        .level_wr_i(level_wr_i), .full_ien_i(full_ien_i), .osc_en_o(osc_en_o),
        .fifo_wr_o(fifo_wr_o), .state_o(state_o), .full_flag_o(full_flag_o),
        .irq_o(irq_o)
    );

    // Vector fields: req[4] en soft force byp[2] pass[2] hfail valid level[7]
    // exp_state[3] exp_osc exp_wr. Each row applies inputs, one clock passes,
    // and outputs are compared. off_delay=2, refill mark 2 blocks = 8 words.
    localparam logic [24:0] VEC [NV] = '{
        25'b0001_0_0_0_00_00_0_0_0000000_000_0_0, // R1 disabled
        25'b0010_1_0_0_00_00_0_1_0000000_001_1_0, // R2 enter STARTUP
        25'b0011_1_0_0_00_00_0_1_0000000_001_1_0, // R3 no pass: hold
        25'b0011_1_0_0_00_10_0_1_0000000_001_1_0, // R3 one pass: hold
        25'b0011_1_0_0_00_11_0_1_0000000_100_1_1, // R3 both pass
        25'b0100_1_0_0_00_11_0_1_0111111_100_1_1, // R4 one below full
        25'b0101_1_0_0_00_11_0_1_1000000_010_1_0, // R5 full: timed wait
        25'b0101_1_0_0_00_11_0_1_1000000_010_1_0, // R5
        25'b0101_1_0_0_00_11_0_1_1000000_010_1_0, // R5 third wait cycle
        25'b0101_1_0_0_00_11_0_1_1000000_011_0_0, // R5 oscillators off
        25'b0111_1_0_0_00_11_0_1_0001001_011_0_0, // R7 above mark
        25'b0111_1_0_0_00_11_0_1_0001000_100_1_1, // R7 at mark
        25'b0110_1_0_1_00_11_0_1_1000000_100_1_0, // R6 force run
        25'b0110_1_0_1_00_11_0_1_1000000_100_1_0, // R6
        25'b0101_1_0_0_00_11_0_1_1000000_010_1_0, // R5 wait again
        25'b1101_1_0_0_00_11_0_1_0101000_100_1_1, // R13 drained early
        25'b1000_1_0_0_00_11_1_1_0101000_101_0_0, // R8 health fail
        25'b1000_1_0_0_00_11_0_1_0101000_101_0_0, // R8 sticky
        25'b1010_1_1_0_00_11_0_1_0101000_000_0_0, // R10 soft reset
        25'b0011_1_0_0_11_00_0_1_0000000_001_1_0, // R3 bypass
        25'b0011_1_0_0_11_00_0_1_0000000_100_1_1, // R3 bypass passes
        25'b1001_0_0_0_11_00_0_1_0000000_000_0_0  // R9 disable
    };

    task automatic check(input string req, input string what,
                         input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset values
        check("R1", "state", state_o, 3'd0);
        check("R1", "osc", {2'b0, osc_en_o}, 3'd0);
        check("R1", "flag", {2'b0, full_flag_o}, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d", v[24:21]);
            enable_i         = v[20];
            soft_rst_i       = v[19];
            force_run_i      = v[18];
            startup_bypass_i = v[17:16];
            startup_pass_i   = v[15:14];
            health_fail_i    = v[13];
            sample_valid_i   = v[12];
            fifo_level_i     = v[11:5];
            step();
            check(tag, $sformatf("state row %0d", i), state_o, v[4:2]);
            check(tag, $sformatf("osc row %0d", i), {2'b0, osc_en_o}, {2'b0, v[1]});
            check(tag, $sformatf("wr row %0d", i), {2'b0, fifo_wr_o}, {2'b0, v[0]});
        end

        // R11 / R12: full flag and interrupt
        soft_rst_i = 1'b0; enable_i = 1'b1; fifo_level_i = 7'd0;
        level_wr_i = 1'b1; step(); level_wr_i = 1'b0;
        check("R11", "flag cleared by write", {2'b0, full_flag_o}, 3'd0);
        fifo_level_i = 7'd64; full_ien_i = 1'b0;
        step();
        check("R11", "flag on full", {2'b0, full_flag_o}, 3'd1);
        check("R12", "irq masked", {2'b0, irq_o}, 3'd0);
        full_ien_i = 1'b1;
        #1;
        check("R12", "irq enabled", {2'b0, irq_o}, 3'd1);
        level_wr_i = 1'b1; step(); level_wr_i = 1'b0;
        step();
        check("R11", "no re-set while full", {2'b0, full_flag_o}, 3'd0);
        check("R12", "irq after clear", {2'b0, irq_o}, 3'd0);
        // R10: soft reset clears the flag
        fifo_level_i = 7'd0; step();
        fifo_level_i = 7'd64; step();
        check("R11", "flag on second fill", {2'b0, full_flag_o}, 3'd1);
        soft_rst_i = 1'b1; step(); soft_rst_i = 1'b0;
        check("R10", "flag after soft reset", {2'b0, full_flag_o}, 3'd0);

        // R9: disable from the oscillators-off state
        fifo_level_i = 7'd0; startup_bypass_i = 2'b11;
        step(); step(); // STARTUP then RUNNING
        fifo_level_i = 7'd64; off_delay_i = 16'd0;
        step(); step();
        check("R5", "zero delay reaches idle", state_o, 3'd3);
        enable_i = 1'b0; step();
        check("R9", "disable from idle", state_o, 3'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule